// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned operands of `OP_WIDTH` bits into a product of twice that width. Each row of the array handles one bit of the Y operand. Every cell in a row ANDs one X bit with that Y bit, then adds the result to the sum and carry vectors coming from the row above. Carries are saved, not propagated, until the last row. A final row of one-bit full adders then ripples them into the upper half of the product. The low half of the product comes straight from the rightmost cell of each row.

Pipeline registers sit after every `ROWS_PER_STAGE` array rows, and the final ripple row forms a stage of its own. Each register captures the operand bits that later rows still need, the partial product bits already finished, the saved sum and carry vectors, and a valid flag. The block therefore accepts a new operand pair every clock. Each result appears a fixed number of cycles later, together with a matching valid flag.

Every cell computes its carry in factored form: the AND of the two addends, ORed with the carry-in ANDed with the OR of the addends. This form keeps every path through the cell robustly delay-testable. The top row has no incoming sum or carry, so its cells are bare AND gates. The second row has no incoming carry, so its cells are half adders.

Top module: `mul_cs_array`

## Requirements
- R1: When `out_valid` is high, `out_product` equals the unsigned product `in_x * in_y` of the pair that produced it, over the full `2*OP_WIDTH`-bit range, including zero and all-ones operands.
- R2: A pair sampled with `in_valid` high on a rising edge appears on `out_valid`/`out_product` after LAT = ceil(OP_WIDTH/ROWS_PER_STAGE) + 1 rising edges, counting that edge as the first. With the default parameters LAT = 3.
- R3: A new pair can be issued on every clock. Results leave one per cycle, in issue order, without stalls.
- R4: Reset is synchronous and active high. On the edge after reset is high, `out_valid` is low, and pairs in flight at that moment never produce a valid output.
- R5: A cycle with `in_valid` low yields `out_valid` low LAT edges later, whatever values the operand inputs carry.
- R6: Each array stage register holds, in carry-save form, `x * (y mod 2^(r+1))`, where r is the last row of that stage. The final ripple row preserves the value of the carry-save vectors it resolves.
- R7: Each cell's outputs satisfy sum + 2*carry = AND-term + sum-in + carry-in. Where all three inputs exist, the carry equals the majority of the three inputs, built as `a&b | ci&(a|b)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; clears every valid flag |
| in_valid | input | 1 | Marks `in_x`/`in_y` as a pair to multiply |
| in_x | input | OP_WIDTH | Multiplicand, unsigned |
| in_y | input | OP_WIDTH | Multiplier, unsigned; bit j drives array row j |
| out_valid | output | 1 | Registered; high when `out_product` holds a result |
| out_product | output | 2*OP_WIDTH | Registered unsigned product |

## Verification
Assertions check the arithmetic of every cell and the carry-save value held in each stage register on every cycle, so an error inside a stage shows up where it arises and not only at the product. They also check that each valid flag follows its input by one stage and that reset clears the output flag. Only the bench's scenarios can show the end-to-end product over every operand pair, the exact latency, ordering under back-to-back issue, bubbles with stray operand values, and loss of in-flight pairs when reset arrives mid-stream.

// File: rtl/mul_cs_pkg.sv
package mul_cs_pkg;

  // Sum of a one-bit full adder.
  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  // Carry in factored form: generate term, plus carry-in gated by the OR of the addends.
  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (ci & (a | b));
  endfunction

endpackage

// File: rtl/mul_cs_cell.sv
module mul_cs_cell
  import mul_cs_pkg::*;
#(
  parameter bit HAS_SUM   = 1'b1,
  parameter bit HAS_CARRY = 1'b1
) (
  input  logic x_bit,
  input  logic y_bit,
  input  logic sum_in,
  input  logic carry_in,
  output logic sum_out,
  output logic carry_out
);

  logic pp;
  logic si;
  logic ci;

  always_comb begin
    pp = x_bit & y_bit;
    si = HAS_SUM   ? sum_in   : 1'b0;
    ci = HAS_CARRY ? carry_in : 1'b0;
  end

  generate
    if (!HAS_SUM && !HAS_CARRY) begin : g_and
      assign sum_out   = pp;
      assign carry_out = 1'b0;
    end else if (HAS_SUM != HAS_CARRY) begin : g_half
      assign sum_out   = pp ^ (si | ci);
      assign carry_out = pp & (si | ci);
    end else begin : g_full
      assign sum_out   = fa_sum(pp, si, ci);
      assign carry_out = fa_carry(pp, si, ci);
    end
  endgenerate

  always_comb begin
    if (!$isunknown({pp, si, ci, sum_out, carry_out})) begin
      AST_CELL_ARITH: assert ({1'b0, sum_out} + {carry_out, 1'b0} ==
                              2'(pp) + 2'(si) + 2'(ci)); // R7
      AST_CELL_MAJORITY: assert (carry_out == ((pp & si) | (pp & ci) | (si & ci))); // R7
    end
  end

endmodule

// File: rtl/mul_cs_stage.sv
module mul_cs_stage
  import mul_cs_pkg::*;
#(
  parameter int OP_WIDTH  = 4,
  parameter int FIRST_ROW = 0,
  parameter int NROWS     = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_in,
  input  logic [OP_WIDTH-1:0]   x_in,
  input  logic [OP_WIDTH-1:0]   y_in,
  input  logic [2*OP_WIDTH-1:0] lo_in,
  input  logic [OP_WIDTH-1:0]   s_in,
  input  logic [OP_WIDTH-1:0]   c_in,
  output logic                  valid_q,
  output logic [OP_WIDTH-1:0]   x_q,
  output logic [OP_WIDTH-1:0]   y_q,
  output logic [2*OP_WIDTH-1:0] lo_q,
  output logic [OP_WIDTH-1:0]   s_q,
  output logic [OP_WIDTH-1:0]   c_q
);

  localparam int N        = OP_WIDTH;
  localparam int PW       = 2 * N;
  localparam int VW       = PW + 2;
  localparam int LAST_ROW = FIRST_ROW + NROWS - 1;
  localparam logic [N-1:0] YMASK = {N{1'b1}} >> (N - 1 - LAST_ROW);

  logic [N-1:0]  s_w [0:NROWS];
  logic [N-1:0]  c_w [0:NROWS];
  logic [PW-1:0] lo_next;

  assign s_w[0] = s_in;
  assign c_w[0] = c_in;

  generate
    for (genvar k = 0; k < NROWS; k++) begin : g_row
      localparam int J = FIRST_ROW + k;
      for (genvar i = 0; i < N; i++) begin : g_col
        if (i < N - 1) begin : g_inner
          mul_cs_cell #(
            .HAS_SUM   (J > 0),
            .HAS_CARRY (J > 1)
          ) u_cell (
            .x_bit     (x_in[i]),
            .y_bit     (y_in[J]),
            .sum_in    (s_w[k][i+1]),
            .carry_in  (c_w[k][i]),
            .sum_out   (s_w[k+1][i]),
            .carry_out (c_w[k+1][i])
          );
        end else begin : g_edge
          mul_cs_cell #(
            .HAS_SUM   (1'b0),
            .HAS_CARRY (J > 1)
          ) u_cell (
            .x_bit     (x_in[i]),
            .y_bit     (y_in[J]),
            .sum_in    (1'b0),
            .carry_in  (c_w[k][i]),
            .sum_out   (s_w[k+1][i]),
            .carry_out (c_w[k+1][i])
          );
        end
      end
    end
  endgenerate

  // The right-edge sum of each row is a finished product bit.
  always_comb begin
    lo_next = lo_in;
    for (int k = 0; k < NROWS; k++) begin
      lo_next[FIRST_ROW + k] = s_w[k+1][0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_in;
    x_q  <= x_in;
    y_q  <= y_in;
    lo_q <= lo_next;
    s_q  <= s_w[NROWS];
    c_q  <= c_w[NROWS];
  end

  logic [VW-1:0] cs_value;
  logic [VW-1:0] ref_value;

  always_comb begin
    cs_value  = VW'(lo_q)
              + (VW'({s_q[N-1:1], 1'b0}) << LAST_ROW)
              + (VW'(c_q) << (LAST_ROW + 1));
    ref_value = VW'(x_q) * VW'(y_q & YMASK);
  end

  AST_STAGE_PARTIAL: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> cs_value == ref_value); // R6

  AST_STAGE_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !rst |=> valid_q == $past(valid_in)); // R3

endmodule

// File: rtl/mul_cs_final.sv
module mul_cs_final
  import mul_cs_pkg::*;
#(
  parameter int OP_WIDTH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_in,
  input  logic [2*OP_WIDTH-1:0] lo_in,
  input  logic [OP_WIDTH-1:0]   s_in,
  input  logic [OP_WIDTH-1:0]   c_in,
  output logic                  valid_q,
  output logic [2*OP_WIDTH-1:0] product_q
);

  localparam int N  = OP_WIDTH;
  localparam int PW = 2 * N;
  localparam int VW = PW + 2;

  logic [N-1:0] add_a;
  logic [N:0]   ripple;
  logic [N-1:0] hi_sum;

  // Operand A of the ripple row is the saved sum shifted one place right.
  assign add_a = {1'b0, s_in[N-1:1]};

  assign ripple[0] = 1'b0;
  generate
    for (genvar i = 0; i < N; i++) begin : g_fa
      assign hi_sum[i]   = fa_sum(add_a[i], c_in[i], ripple[i]);
      assign ripple[i+1] = fa_carry(add_a[i], c_in[i], ripple[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_in;
    product_q <= {hi_sum, lo_in[N-1:0]};
  end

  logic [VW-1:0] in_value;
  always_comb begin
    in_value = VW'(lo_in)
             + (VW'({s_in[N-1:1], 1'b0}) << (N - 1))
             + (VW'(c_in) << N);
  end

  AST_CPA_VALUE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (!valid_q || VW'(product_q) == $past(in_value))); // R6

  AST_CPA_NO_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
    valid_in |-> !ripple[N]); // R1

endmodule

// File: rtl/mul_cs_array.sv
module mul_cs_array #(
  parameter int OP_WIDTH       = 4,
  parameter int ROWS_PER_STAGE = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [OP_WIDTH-1:0]   in_x,
  input  logic [OP_WIDTH-1:0]   in_y,
  output logic                  out_valid,
  output logic [2*OP_WIDTH-1:0] out_product
);

  localparam int N    = OP_WIDTH;
  localparam int PW   = 2 * N;
  localparam int NSTG = (N + ROWS_PER_STAGE - 1) / ROWS_PER_STAGE;

  logic          v_b  [0:NSTG];
  logic [N-1:0]  x_b  [0:NSTG];
  logic [N-1:0]  y_b  [0:NSTG];
  logic [PW-1:0] lo_b [0:NSTG];
  logic [N-1:0]  s_b  [0:NSTG];
  logic [N-1:0]  c_b  [0:NSTG];

  assign v_b[0]  = in_valid;
  assign x_b[0]  = in_x;
  assign y_b[0]  = in_y;
  assign lo_b[0] = '0;
  assign s_b[0]  = '0;
  assign c_b[0]  = '0;

  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
      localparam int FIRST = g * ROWS_PER_STAGE;
      localparam int ROWS  = (FIRST + ROWS_PER_STAGE <= N) ? ROWS_PER_STAGE : (N - FIRST);
      mul_cs_stage #(
        .OP_WIDTH  (N),
        .FIRST_ROW (FIRST),
        .NROWS     (ROWS)
      ) u_stage (
        .clk      (clk),
        .rst      (rst),
        .valid_in (v_b[g]),
        .x_in     (x_b[g]),
        .y_in     (y_b[g]),
        .lo_in    (lo_b[g]),
        .s_in     (s_b[g]),
        .c_in     (c_b[g]),
        .valid_q  (v_b[g+1]),
        .x_q      (x_b[g+1]),
        .y_q      (y_b[g+1]),
        .lo_q     (lo_b[g+1]),
        .s_q      (s_b[g+1]),
        .c_q      (c_b[g+1])
      );
    end
  endgenerate

  mul_cs_final #(
    .OP_WIDTH (N)
  ) u_final (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (v_b[NSTG]),
    .lo_in     (lo_b[NSTG]),
    .s_in      (s_b[NSTG]),
    .c_in      (c_b[NSTG]),
    .valid_q   (out_valid),
    .product_q (out_product)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !out_valid); // R4

endmodule

// File: tb/mul_cs_array_bench.sv
`timescale 1ns/1ps
module mul_cs_array_bench;

  localparam int N    = 4;
  localparam int RPS  = 2;
  localparam int PW   = 2 * N;
  localparam int LAT  = (N + RPS - 1) / RPS + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [N-1:0]  in_x;
  logic [N-1:0]  in_y;
  logic          out_valid;
  logic [PW-1:0] out_product;

  int checks   = 0;
  int failures = 0;

  logic          ev [0:LAT-1];
  logic [PW-1:0] ep [0:LAT-1];

  mul_cs_array #(
    .OP_WIDTH       (N),
    .ROWS_PER_STAGE (RPS)
  ) u_mul_cs_array (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_x        (in_x),
    .in_y        (in_y),
    .out_valid   (out_valid),
    .out_product (out_product)
  );

  always #10 clk = ~clk;

  function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  task automatic check_out(input string req);
    checks++;
    if (out_valid !== ev[LAT-1]) begin
      failures++;
      $display("FAIL %s out_valid actual=%b expected=%b", req, out_valid, ev[LAT-1]);
    end
    if (ev[LAT-1]) begin
      // Product value; the carry-save stages (R6) and cells (R7) feed it.
      checks++;
      if (out_product !== ep[LAT-1]) begin
        failures++;
        $display("FAIL R1/R6/R7 out_product actual=%0d expected=%0d", out_product, ep[LAT-1]);
      end
    end
  endtask

  task automatic step(input logic v, input logic [N-1:0] a, input logic [N-1:0] b,
                      input string req);
    in_valid = v;
    in_x     = a;
    in_y     = b;
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < LAT; k++) ev[k] = 1'b0;
    end else begin
      for (int k = LAT - 1; k > 0; k--) begin
        ev[k] = ev[k-1];
        ep[k] = ep[k-1];
      end
      ev[0] = v;
      ep[0] = ref_mul(a, b);
    end
    @(negedge clk);
    check_out(req);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    in_valid = 1'b0;
    in_x = '0;
    in_y = '0;
    for (int k = 0; k < LAT; k++) begin
      ev[k] = 1'b0;
      ep[k] = '0;
    end
    @(negedge clk);
    // R4: reset state
    for (int k = 0; k < 3; k++) step(1'b1, 4'd5, 4'd6, "R4");
    rst = 1'b0;

    // Directed corners, then a lone pair to expose latency (R2)
    step(1'b1, '0, '0, "R2");
    step(1'b1, '1, '1, "R2");
    step(1'b1, 4'd1, 4'd13, "R2");
    step(1'b1, 4'd13, 4'd1, "R2");
    step(1'b1, 4'd8, 4'd8, "R2");
    for (int k = 0; k < LAT + 1; k++) step(1'b0, '1, '1, "R5");
    step(1'b1, 4'd11, 4'd7, "R2");
    for (int k = 0; k < LAT + 1; k++) step(1'b0, 4'd9, 4'd3, "R5");

    // R3: every operand pair back to back
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        step(1'b1, N'(a), N'(b), "R3");
      end
    end

    // Random issue with bubbles carrying stray operands (R5)
    for (int k = 0; k < 300; k++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, N'($urandom), N'($urandom), v ? "R3" : "R5");
    end

    // R4: reset while pairs are in flight
    step(1'b1, 4'd12, 4'd14, "R3");
    step(1'b1, 4'd15, 4'd3, "R3");
    rst = 1'b1;
    step(1'b1, 4'd7, 4'd9, "R4");
    rst = 1'b0;
    for (int k = 0; k < LAT + 1; k++) step(1'b0, '1, '1, "R4");
    step(1'b1, 4'd10, 4'd10, "R2");
    for (int k = 0; k < LAT + 1; k++) step(1'b0, '0, '0, "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule